// File: doc/BRIEF.md
# Two-Channel Byte-Loaded Converter Code Register

This block is the register front end for a pair of 12-bit digital-to-analog converters that are fed from an 8-bit processor bus. Each channel has a staging register, which software fills one byte at a time, and a separate output register whose contents are the code presented to the converter. A 12-bit value therefore needs two bus writes to reach the staging register. It moves to the output only when a transfer command arrives. The converter never sees a code in which one half is new and the other half is old.

A bus write names its target with two selects: a channel select (0 for channel 0, 1 for channel 1) and a segment select (0 for bits 7..0, 1 for bits 11..8). The write is framed by an active-low chip select and an active-low write strobe, both sampled on the system clock. The write takes effect when the strobe returns high.

The transfer command is a single-cycle pulse that carries one mask bit per channel. Setting both mask bits updates both outputs on the same clock edge. The bus interface has no back-pressure: every framed write and every transfer is accepted in the cycle it completes, so the host needs no handshake.

Top module: `dual_code_loader`

## Requirements
- R1: While reset is asserted, and after it is released, both staging registers and both output codes hold zero.
- R2: A completed write with `hi_sel`=0 puts `bus_d[7:0]` into bits 7..0 of the staging register of the channel chosen by `ch_sel`. Bits 11..8 of that register and the other channel's register are left unchanged.
- R3: A completed write with `hi_sel`=1 puts `bus_d[3:0]` into bits 11..8 of the chosen staging register. `bus_d[7:4]` is ignored, and bits 7..0 are left unchanged.
- R4: Only the output register drives `dac_code`. A write to a staging register without a transfer leaves `dac_code` unchanged.
- R5: A write completes on the first clock edge at which `wr_n` is sampled high after having been sampled low. The select and data values it uses are those sampled on the last edge where `wr_n` was low. If `cs_n` was high on that edge, nothing is written. Holding `wr_n` low for several cycles writes nothing until the strobe rises.
- R6: A clock edge with `xfer_go`=1 copies the staging register into the output register for every channel whose `xfer_mask` bit is 1. Bit 0 selects channel 0, and a mask of 2'b11 updates both channels on the same edge.
- R7: When a write completes on the same edge as a transfer that selects the written channel, the output receives the staging value that includes the new byte.
- R8: A transfer leaves the output of every channel whose mask bit is 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select qualifying a bus write |
| wr_n | input | 1 | Active-low write strobe; the write completes on its rising transition |
| ch_sel | input | 1 | Channel targeted by the write (0 or 1) |
| hi_sel | input | 1 | Segment targeted: 0 for bits 7..0, 1 for bits 11..8 |
| bus_d | input | 8 | Processor data bus |
| xfer_go | input | 1 | One-cycle transfer command |
| xfer_mask | input | 2 | Per-channel transfer enable; bit i selects channel i |
| dac_code | output | 24 | Output codes: bits 11..0 for channel 0, bits 23..12 for channel 1 |

## Verification
The hardest case to reach is a byte write that completes on the very edge of a transfer. The strobe's rising transition and the transfer pulse must be sampled on the same clock edge, and the bus values must come from the cycle before. The bench reaches it by driving the strobe high and raising `xfer_go` on the same falling clock edge. It then checks that the output carries the freshly written high nibble together with the low byte that was already staged. A second scenario holds the strobe low across a transfer, to show that a write which has not completed is invisible even to a transfer.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    SEG_LOW  = 1'b0,
    SEG_HIGH = 1'b1
  } seg_e;

  typedef struct packed {
    logic  valid;
    seg_e  seg;
    byte_t data;
  } wr_cmd_t;

endpackage

// File: rtl/dcl_bus_capture.sv
module dcl_bus_capture
  import dcl_pkg::*;
#(
  parameter int unsigned CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic [CH_W-1:0] ch_sel,
  input  logic            hi_sel,
  input  byte_t           bus_d,
  output wr_cmd_t         cmd_o,
  output logic [CH_W-1:0] ch_o
);

  logic            wr_q;
  logic            cs_q;
  logic [CH_W-1:0] ch_q;
  logic            hi_q;
  byte_t           d_q;

  // strobe history; reset high so no phantom edge appears at release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  // bus fields follow the bus while the strobe is low and freeze once it rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      ch_q <= '0;
      hi_q <= 1'b0;
      d_q  <= '0;
    end else if (!wr_n) begin
      cs_q <= cs_n;
      ch_q <= ch_sel;
      hi_q <= hi_sel;
      d_q  <= bus_d;
    end
  end

  always_comb begin
    cmd_o.valid = wr_n & ~wr_q & ~cs_q;
    cmd_o.seg   = hi_q ? SEG_HIGH : SEG_LOW;
    cmd_o.data  = d_q;
    ch_o        = ch_q;
  end

  AST_CMD_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o.valid |-> (wr_n && !$past(wr_n))); // R5
  AST_CMD_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o.valid |-> !$past(cs_n)); // R5

endmodule

// File: rtl/dcl_decode.sv
module dcl_decode
  import dcl_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned CH_W = 1
) (
  input  wr_cmd_t         cmd_i,
  input  logic [CH_W-1:0] ch_i,
  output logic [NCH-1:0]  we_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_we
    assign we_o[g] = cmd_i.valid && (ch_i == CH_W'(g));
  end

  always_comb begin
    AST_SINGLE_TARGET: assert ($onehot0(we_o)); // R2
  end

endmodule

// File: rtl/dcl_channel.sv
module dcl_channel
  import dcl_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_i,
  input  wr_cmd_t           cmd_i,
  input  logic              load_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned LO_W = BYTE_W;
  localparam int unsigned HI_W = CODE_W - LO_W;

  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] stage_nxt;
  logic [CODE_W-1:0] out_q;

  // merge a byte write into the staging word
  always_comb begin
    stage_nxt = stage_q;
    if (wen_i) begin
      if (cmd_i.seg == SEG_HIGH) stage_nxt[CODE_W-1:LO_W] = cmd_i.data[HI_W-1:0];
      else                       stage_nxt[LO_W-1:0]      = cmd_i.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nxt;
  end

  // output register loads the merged word, so a same-edge write is included
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (load_i) out_q <= stage_nxt;
  end

  assign code_o = out_q;

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(code_o)); // R4
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wen_i) |=> (code_o == $past(stage_q))); // R6
  AST_MERGED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && wen_i && cmd_i.seg == SEG_HIGH)
      |=> (code_o[CODE_W-1:LO_W] == $past(cmd_i.data[HI_W-1:0]))); // R7
  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i && cmd_i.seg == SEG_LOW) |=> $stable(stage_q[CODE_W-1:LO_W])); // R2
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i && cmd_i.seg == SEG_HIGH) |=> $stable(stage_q[LO_W-1:0])); // R3

endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic [CH_W-1:0]       ch_sel,
  input  logic                  hi_sel,
  input  logic [BYTE_W-1:0]     bus_d,
  input  logic                  xfer_go,
  input  logic [NCH-1:0]        xfer_mask,
  output logic [NCH*CODE_W-1:0] dac_code
);

  wr_cmd_t         cmd;
  logic [CH_W-1:0] cmd_ch;
  logic [NCH-1:0]  we;
  logic [NCH-1:0]  load;

  dcl_bus_capture #(.CH_W(CH_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .ch_sel (ch_sel),
    .hi_sel (hi_sel),
    .bus_d  (bus_d),
    .cmd_o  (cmd),
    .ch_o   (cmd_ch)
  );

  dcl_decode #(.NCH(NCH), .CH_W(CH_W)) u_decode (
    .cmd_i (cmd),
    .ch_i  (cmd_ch),
    .we_o  (we)
  );

  assign load = {NCH{xfer_go}} & xfer_mask;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dcl_channel #(.CODE_W(CODE_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wen_i  (we[g]),
      .cmd_i  (cmd),
      .load_i (load[g]),
      .code_o (dac_code[g*CODE_W +: CODE_W])
    );
  end

  AST_MASKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !xfer_mask[0]) |=> $stable(dac_code[CODE_W-1:0])); // R8

endmodule

// File: tb/dual_code_loader_test.sv
`timescale 1ns/1ps
module dual_code_loader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ch_sel = 1'b0;
  logic        hi_sel = 1'b0;
  logic [7:0]  bus_d = '0;
  logic        xfer_go = 1'b0;
  logic [1:0]  xfer_mask = '0;
  logic [23:0] dac_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] stg_m [2];
  logic [11:0] out_m [2];

  always #2 clk = ~clk;

  dual_code_loader uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ch_sel(ch_sel),
    .hi_sel(hi_sel), .bus_d(bus_d), .xfer_go(xfer_go), .xfer_mask(xfer_mask),
    .dac_code(dac_code)
  );

  task automatic check_out(input string req);
    for (int c = 0; c < 2; c++) begin
      n_chk++;
      if (dac_code[c*12 +: 12] !== out_m[c]) begin
        n_bad++;
        $display("FAIL %s ch%0d: actual %h expected %h", req, c, dac_code[c*12 +: 12], out_m[c]);
      end
    end
  endtask

  task automatic model_xfer(input logic [1:0] m);
    for (int c = 0; c < 2; c++) if (m[c]) out_m[c] = stg_m[c];
  endtask

  // one framed bus write; the optional transfer is sampled on the completing edge
  task automatic bus_write(input logic ch, input logic hi, input logic [7:0] d,
                           input logic sel_n, input logic xf, input logic [1:0] m);
    @(negedge clk);
    cs_n = sel_n; ch_sel = ch; hi_sel = hi; bus_d = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; xfer_go = xf; xfer_mask = m;
    @(negedge clk);
    xfer_go = 1'b0; cs_n = 1'b1; bus_d = 8'hxx;
    if (!sel_n) begin
      if (hi) stg_m[ch][11:8] = d[3:0];
      else    stg_m[ch][7:0]  = d;
    end
    if (xf) model_xfer(m);
  endtask

  task automatic do_xfer(input logic [1:0] m);
    @(negedge clk);
    xfer_go = 1'b1; xfer_mask = m;
    @(negedge clk);
    xfer_go = 1'b0;
    model_xfer(m);
  endtask

  task automatic t_reset;
    for (int c = 0; c < 2; c++) begin stg_m[c] = '0; out_m[c] = '0; end
    #1 check_out("R1 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_out("R1 after release");
    do_xfer(2'b11);
    check_out("R1 staging cleared");
  endtask

  task automatic t_low_byte;
    bus_write(1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 2'b00);
    check_out("R4 low write hidden");
    do_xfer(2'b01);
    check_out("R2 low byte ch0");
  endtask

  task automatic t_high_byte;
    bus_write(1'b0, 1'b1, 8'hF3, 1'b0, 1'b0, 2'b00);
    check_out("R4 high write hidden");
    do_xfer(2'b01);
    check_out("R3 high nibble, upper bus bits ignored");
  endtask

  task automatic t_deselected;
    bus_write(1'b1, 1'b0, 8'h77, 1'b1, 1'b0, 2'b00);
    do_xfer(2'b11);
    check_out("R5 cs_n high writes nothing");
  endtask

  task automatic t_both_channels;
    bus_write(1'b1, 1'b0, 8'h12, 1'b0, 1'b0, 2'b00);
    bus_write(1'b1, 1'b1, 8'h0C, 1'b0, 1'b0, 2'b00);
    bus_write(1'b0, 1'b0, 8'h34, 1'b0, 1'b0, 2'b00);
    bus_write(1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 2'b00);
    check_out("R4 staged codes not visible");
    do_xfer(2'b11);
    check_out("R6 both channels together");
  endtask

  task automatic t_same_edge;
    bus_write(1'b0, 1'b1, 8'h09, 1'b0, 1'b1, 2'b01);
    check_out("R7 write merged into same-edge transfer");
  endtask

  task automatic t_mask_one;
    bus_write(1'b0, 1'b0, 8'hEE, 1'b0, 1'b0, 2'b00);
    bus_write(1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, 2'b00);
    do_xfer(2'b10);
    check_out("R8 masked ch0 unchanged, ch1 loaded");
    do_xfer(2'b01);
    check_out("R6 ch0 loaded afterwards");
  endtask

  task automatic t_long_strobe;
    @(negedge clk);
    cs_n = 1'b0; ch_sel = 1'b1; hi_sel = 1'b1; bus_d = 8'h07; wr_n = 1'b0;
    @(negedge clk);
    xfer_go = 1'b1; xfer_mask = 2'b10;
    @(negedge clk);
    xfer_go = 1'b0;
    model_xfer(2'b10);
    check_out("R5 strobe still low, no write yet");
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    stg_m[1][11:8] = 4'h7;
    check_out("R4 completed write hidden");
    do_xfer(2'b10);
    check_out("R5 write completed on rise");
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_low_byte();
    t_high_byte();
    t_deselected();
    t_both_channels();
    t_same_edge();
    t_mask_one();
    t_long_strobe();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule